// File: doc/BRIEF.md
# Adapter Presence Qualifier with Deglitch

This block decides when an external power adapter may be treated as a valid supply source. It sees only the digital results of analog comparators: the adapter-detect node against a low bias threshold and a higher valid threshold, the supply against undervoltage lockout and against battery voltage, a pair of overvoltage trip and release flags, and a flag that reports whether supply or battery is above its own lockout level. From these it drives an active-high adapter-valid flag, a bias-enable flag, and a status bit that software can read.

Qualification is asymmetric. A rising condition must hold for a long, history-dependent interval before the valid flag asserts. The interval is short for the first plug-in after power-up and long for every later plug-in, and a configuration input can force the long interval at all times. A loss of qualification drops the flag after only a few microsecond ticks. Overvoltage is held in a hysteresis latch. While that latch is set, the flag is pulled low at once. All comparator inputs pass through a synchronizer, and all intervals are counted in ticks of an external one-microsecond strobe, using terminal counts set by parameters.

Top module: `adapter_qualifier`

## Requirements
- R1: `valid_o` rises only after detect-above-valid, supply-above-lockout and supply-above-battery have all held high with the overvoltage latch clear. With any one of them low, `valid_o` stays low indefinitely.
- R2: `bias_en_o` is high exactly when detect-above-bias and supply-above-lockout are both high, three clock cycles after the inputs change, whatever the state of `valid_o`.
- R3: On the first qualification after the lockout flag `pwr_up_i` was last seen low, `valid_o` rises after `SHORT_TC` ticks of continuous qualification.
- R4: On every later qualification, `valid_o` rises after `LONG_TC` ticks.
- R5: While `long_only_i` is 1, the `LONG_TC` interval applies even to the first qualification.
- R6: A low level on `pwr_up_i` clears the plug-in history, so the next qualification uses `SHORT_TC` again.
- R7: If qualification is lost at any point during the rising count, the count restarts from zero.
- R8: When qualification is lost, `valid_o` falls after `FALL_TC` ticks. A loss that ends before the next tick leaves `valid_o` high.
- R9: A high `ovp_trip_i` sets the overvoltage latch, and `ovp_release_i` clears it. Trip wins when both are high. While the latch is set, `valid_o` goes low within four cycles with no tick needed, and it stays low after the trip flag drops, until the latch is released.
- R10: `valid_status_o` always equals `valid_o`.
- R11: After reset, `valid_o`, `valid_status_o` and `bias_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle strobe every microsecond |
| det_bias_i | input | 1 | Adapter detect above bias threshold |
| det_valid_i | input | 1 | Adapter detect above valid threshold |
| sup_uvlo_ok_i | input | 1 | Supply above undervoltage lockout |
| sup_gt_bat_i | input | 1 | Supply above battery voltage |
| ovp_trip_i | input | 1 | Supply above overvoltage trip level |
| ovp_release_i | input | 1 | Supply below overvoltage release level |
| pwr_up_i | input | 1 | Supply or battery above its lockout level |
| long_only_i | input | 1 | Always use the long rising interval |
| valid_o | output | 1 | Adapter valid |
| bias_en_o | output | 1 | Bias circuits enable |
| valid_status_o | output | 1 | Readable copy of adapter valid |

## Verification
The bench builds the block with `SHORT_TC` = 20, `LONG_TC` = 50 and `FALL_TC` = 3, and drives one tick every four clocks. At these values both rising intervals are reached within a few hundred cycles, and the measured counts of 20 and 50 cannot be confused, so first-plug, later-plug, history-clear, forced-long and count-restart behaviour are told apart by tick counts alone. Tick gating lets the bench hold a short loss of qualification entirely between ticks, and it lets the bench show that overvoltage pulls the flag low without any tick.

// File: rtl/adq_pkg.sv
package adq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HELD = 2'd2,
    ST_DROP = 2'd3
  } adq_state_e;

  typedef struct packed {
    logic det_bias;
    logic det_valid;
    logic sup_uvlo;
    logic sup_gt_bat;
    logic ovp_trip;
    logic ovp_release;
    logic pwr_up;
  } adq_flags_t;

  localparam int ADQ_FLAG_W = $bits(adq_flags_t);

endpackage

// File: rtl/adq_sync.sv
module adq_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign q_o[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/adq_ovp_latch.sv
module adq_ovp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic release_i,
  output logic active_o
);

  logic act_q;
  logic act_d;

  always_comb begin
    act_d = act_q;
    if (trip_i)         act_d = 1'b1;
    else if (release_i) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign active_o = act_q;

  AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_i && !release_i) |=> $stable(active_o)); // R9
  AST_OVP_TRIP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> active_o); // R9

endmodule

// File: rtl/adq_deglitch.sv
module adq_deglitch
  import adq_pkg::*;
#(
  parameter int SHORT_TC = 150000,
  parameter int LONG_TC  = 1300000,
  parameter int FALL_TC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic qual_i,
  input  logic force_off_i,
  input  logic pwr_up_i,
  input  logic long_only_i,
  output logic valid_o
);

  localparam int CW = $clog2(LONG_TC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TC - 1);
  localparam logic [CW-1:0] FALL_LAST  = CW'(FALL_TC - 1);

  adq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d;
  logic [CW-1:0] rise_last;

  always_comb begin
    rise_last = (long_only_i || first_q) ? LONG_LAST : SHORT_LAST;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (qual_i && !force_off_i) st_d = ST_ARM;
      end
      ST_ARM: begin
        if (force_off_i || !qual_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (tick_i) begin
          if (cnt_q == rise_last) begin
            st_d  = ST_HELD;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_HELD: begin
        cnt_d = '0;
        if (force_off_i)  st_d = ST_IDLE;
        else if (!qual_i) st_d = ST_DROP;
      end
      ST_DROP: begin
        if (force_off_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (qual_i) begin
          st_d  = ST_HELD;
          cnt_d = '0;
        end else if (tick_i) begin
          if (cnt_q == FALL_LAST) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_comb begin
    first_d = first_q;
    if (!pwr_up_i)                             first_d = 1'b0;
    else if (st_q == ST_ARM && st_d == ST_HELD) first_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign valid_o = (st_q == ST_HELD) || (st_q == ST_DROP);

  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> ($past(qual_i) && $past(tick_i))); // R1
  AST_FALL_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !tick_i && !force_off_i) |=> valid_o); // R8
  AST_HISTORY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |=> !first_q); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_LAST); // R4

endmodule

// File: rtl/adapter_qualifier.sv
module adapter_qualifier
  import adq_pkg::*;
#(
  parameter int SHORT_TC    = 150000,
  parameter int LONG_TC     = 1300000,
  parameter int FALL_TC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us_i,
  input  logic det_bias_i,
  input  logic det_valid_i,
  input  logic sup_uvlo_ok_i,
  input  logic sup_gt_bat_i,
  input  logic ovp_trip_i,
  input  logic ovp_release_i,
  input  logic pwr_up_i,
  input  logic long_only_i,
  output logic valid_o,
  output logic bias_en_o,
  output logic valid_status_o
);

  adq_flags_t raw_flags;
  adq_flags_t syn_flags;
  logic       ovp_act;
  logic       qual;
  logic       bias_q, bias_d;
  logic       valid_int;

  always_comb begin
    raw_flags.det_bias    = det_bias_i;
    raw_flags.det_valid   = det_valid_i;
    raw_flags.sup_uvlo    = sup_uvlo_ok_i;
    raw_flags.sup_gt_bat  = sup_gt_bat_i;
    raw_flags.ovp_trip    = ovp_trip_i;
    raw_flags.ovp_release = ovp_release_i;
    raw_flags.pwr_up      = pwr_up_i;
  end

  adq_sync #(
    .WIDTH  (ADQ_FLAG_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_flags),
    .q_o   (syn_flags)
  );

  adq_ovp_latch ovp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_i    (syn_flags.ovp_trip),
    .release_i (syn_flags.ovp_release),
    .active_o  (ovp_act)
  );

  always_comb begin
    qual = syn_flags.det_valid && syn_flags.sup_uvlo &&
           syn_flags.sup_gt_bat && !ovp_act;
  end

  adq_deglitch #(
    .SHORT_TC (SHORT_TC),
    .LONG_TC  (LONG_TC),
    .FALL_TC  (FALL_TC)
  ) dg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_us_i),
    .qual_i      (qual),
    .force_off_i (ovp_act),
    .pwr_up_i    (syn_flags.pwr_up),
    .long_only_i (long_only_i),
    .valid_o     (valid_int)
  );

  always_comb begin
    bias_d = syn_flags.det_bias && syn_flags.sup_uvlo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bias_q <= 1'b0;
    else        bias_q <= bias_d;
  end

  assign valid_o        = valid_int;
  assign valid_status_o = valid_int;
  assign bias_en_o      = bias_q;

  AST_OVP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_act |=> !valid_o); // R9
  AST_VALID_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(syn_flags.det_valid && syn_flags.sup_gt_bat)); // R1

endmodule

// File: tb/adapter_qualifier_tb.sv
module adapter_qualifier_tb_top;

  localparam int SHORT = 20;
  localparam int LONG  = 50;
  localparam int FALL  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tick_en = 1'b0;
  logic [1:0] div = 2'd0;
  logic det_bias = 1'b0, det_valid = 1'b0, uvlo = 1'b0, gt_bat = 1'b0;
  logic ovp_trip = 1'b0, ovp_rel = 1'b0, pwr_up = 1'b0, long_only = 1'b0;
  logic valid, bias_en, status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    div <= div + 2'd1;
    tick <= tick_en && (div == 2'd3);
  end

  adapter_qualifier #(
    .SHORT_TC (SHORT),
    .LONG_TC  (LONG),
    .FALL_TC  (FALL)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_us_i      (tick),
    .det_bias_i     (det_bias),
    .det_valid_i    (det_valid),
    .sup_uvlo_ok_i  (uvlo),
    .sup_gt_bat_i   (gt_bat),
    .ovp_trip_i     (ovp_trip),
    .ovp_release_i  (ovp_rel),
    .pwr_up_i       (pwr_up),
    .long_only_i    (long_only),
    .valid_o        (valid),
    .bias_en_o      (bias_en),
    .valid_status_o (status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts ticks from now until valid reaches level; -1 on timeout
  task automatic meas(input logic level, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (valid == level) return;
      if (tick) n++;
    end
    n = -1;
  endtask

  task automatic wait_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  task automatic unplug;
    int n;
    det_valid = 1'b0;
    meas(1'b0, n);
  endtask

  task automatic t_reset;
    check("R11 valid after reset", valid, 0);
    check("R11 status after reset", status, 0);
    check("R11 bias after reset", bias_en, 0);
  endtask

  task automatic t_bias;
    pwr_up = 1'b1; uvlo = 1'b1; det_bias = 1'b1;
    wait_cyc(2);
    check("R2 bias not before three cycles", bias_en, 0);
    wait_cyc(1);
    check("R2 bias high", bias_en, 1);
    check("R2 valid stays low without detect", valid, 0);
    uvlo = 1'b0;
    wait_cyc(4);
    check("R2 bias low without lockout ok", bias_en, 0);
    uvlo = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_first;
    int n;
    tick_en = 1'b1; gt_bat = 1'b1; det_valid = 1'b1;
    meas(1'b1, n);
    check_rng("R3 first plug ticks", n, SHORT, SHORT + 1);
    check("R10 status mirrors high", status, 1);
    check("R2 bias independent of valid", bias_en, 1);
  endtask

  task automatic t_fall;
    int n;
    int dropped = 0;
    tick_en = 1'b0;
    wait_cyc(2);
    det_valid = 1'b0;
    wait_cyc(3);
    det_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!valid) dropped = 1;
    end
    check("R8 brief loss ignored", dropped, 0);
    tick_en = 1'b1;
    det_valid = 1'b0;
    meas(1'b0, n);
    check_rng("R8 fall ticks", n, FALL, FALL + 1);
    check("R10 status mirrors low", status, 0);
  endtask

  task automatic t_second;
    int n;
    det_valid = 1'b1;
    meas(1'b1, n);
    check_rng("R4 later plug ticks", n, LONG, LONG + 1);
    unplug();
  endtask

  task automatic t_block;
    gt_bat = 1'b0; det_valid = 1'b1;
    wait_ticks(LONG + 20);
    check("R1 no valid with supply below battery", valid, 0);
    gt_bat = 1'b1; uvlo = 1'b0;
    wait_ticks(LONG + 20);
    check("R1 no valid under lockout", valid, 0);
    uvlo = 1'b1; det_valid = 1'b0;
    wait_cyc(8);
  endtask

  task automatic t_restart;
    int n;
    det_valid = 1'b1;
    wait_ticks(30);
    check("R7 still counting", valid, 0);
    det_valid = 1'b0;
    wait_cyc(8);
    det_valid = 1'b1;
    meas(1'b1, n);
    check_rng("R7 count restarted", n, LONG, LONG + 1);
    unplug();
  endtask

  task automatic t_lockout;
    int n;
    pwr_up = 1'b0;
    wait_cyc(6);
    pwr_up = 1'b1;
    wait_cyc(4);
    det_valid = 1'b1;
    meas(1'b1, n);
    check_rng("R6 history cleared short again", n, SHORT, SHORT + 1);
    unplug();
  endtask

  task automatic t_cfg;
    int n;
    pwr_up = 1'b0;
    wait_cyc(6);
    pwr_up = 1'b1; long_only = 1'b1;
    wait_cyc(4);
    det_valid = 1'b1;
    meas(1'b1, n);
    check_rng("R5 forced long on first plug", n, LONG, LONG + 1);
    unplug();
    long_only = 1'b0;
  endtask

  task automatic t_ovp;
    int n;
    det_valid = 1'b1;
    meas(1'b1, n);
    check("R9 valid high before trip", valid, 1);
    tick_en = 1'b0;
    wait_cyc(2);
    ovp_trip = 1'b1;
    wait_cyc(4);
    check("R9 trip drops valid without tick", valid, 0);
    ovp_trip = 1'b0;
    tick_en = 1'b1;
    wait_ticks(LONG + 20);
    check("R9 latch holds valid low", valid, 0);
    ovp_rel = 1'b1;
    meas(1'b1, n);
    check_rng("R9 release rearms long count", n, LONG, LONG + 2);
    ovp_trip = 1'b1;
    wait_cyc(6);
    check("R9 trip wins over release", valid, 0);
    wait_ticks(LONG + 10);
    check("R9 stays low while both high", valid, 0);
    ovp_trip = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bias();
    t_first();
    t_fall();
    t_second();
    t_block();
    t_restart();
    t_lockout();
    t_cfg();
    t_ovp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule